// File: doc/BRIEF.md
# Flash Command Interface with Erase Status Polling

This block is the command front end of a 16-bit-wide reprogrammable memory. It watches write cycles on a simple synchronous bus for multi-write unlock sequences. It decodes two operations: an identification read mode and a whole-chip automatic erase. Array reads pass through from an external array model, and the block drives a small command code that tells the array when to clear to zeros and when to erase to ones.

The automatic erase runs with no help from the host. It first preprograms the whole array to zero, then erases it. Each phase lasts a parameterised number of clock cycles. While the erase runs, every read returns a status word instead of array data. In that word a polarity bit reads 0, a toggle bit flips on every read, and a timeout bit rises once the run has gone past its cycle limit. A timed-out run stays busy until the hardware reset. The hardware reset also aborts a running erase at once.

The bus is plain: one write or one read per clock while chip enable is high. It has no back-pressure. Every accepted strobe completes in the cycle it is sampled, and the busy pin is the only flow indicator.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, arr_cmd is 0 (idle), and a read returns arr_rdata unchanged.
- R2: The writes 0xAA at word address 0x555, 0x55 at 0x2AA, and 0x90 at 0x555 enter ID mode. In ID mode, a read with address bits 6, 1 and 0 all 0 returns 0x00C2. With bit 6 = 0, bit 1 = 0 and bit 0 = 1 it returns 0x22FE. Any other address returns 0x0000. Writing data 0xF0 returns to array reads.
- R3: Six writes start the erase: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555. Busy is 1 in the clock that follows the sixth write.
- R4: A write that does not match the next expected step returns the decoder to its start, so the remaining steps of a broken sequence start nothing.
- R5: An erase holds busy for exactly PRE_CYC + ERS_CYC cycles. arr_cmd is 1 (preprogram to zero) for the first PRE_CYC cycles and 2 (erase to ones) for the last ERS_CYC cycles. It never goes from 2 back to 1.
- R6: While busy, all writes are ignored, including 0xF0 and a full ID sequence. After the erase, reads return array data.
- R7: While busy, the read word has bit 7 = 0 and bits 15:8 and 4:0 = 0. Once the erase completes, reads return array data again (0xFFFF after an erase).
- R8: While busy, bit 6 of the read word starts at 0 for the first read and inverts on each later read, whatever the address.
- R9: Bit 5 reads 0 until TOUT_CYC busy cycles have passed without completion. After that it reads 1, busy stays 1 and bit 6 keeps toggling until hardware reset.
- R10: Asserting rst_n low during an erase drops busy and arr_cmd to 0 at once. After release, reads return array data and a new erase sequence is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous; aborts erase |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write strobe, sampled with ce |
| re | input | 1 | Read strobe, sampled with ce; advances the toggle bit while busy |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; bits 7:0 carry the command |
| arr_rdata | input | 16 | Data from the array at addr |
| rdata | output | 16 | Read data: array, ID code or status word |
| busy | output | 1 | Automatic erase running or timed out |
| arr_cmd | output | 2 | Array operation: 0 none, 1 preprogram to zero, 2 erase to ones |

## Verification
A sequencer left in a stale step shows up as an erase or ID mode after a broken or partial sequence. The first read or busy sample after the final write exposes it. An erase phase counter that is off shows as busy lasting a cycle too long or too short, or as arr_cmd switching at the wrong cycle, and counting negedges through one erase catches it. A toggle or timeout flag that is wrong or stuck changes bits 6 and 5 on the next status read. A reset path that does not clear the engine leaves busy high in the first cycle of reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_SETUP, SQ_SU1, SQ_SU2
  } seq_t;

  typedef enum logic [1:0] {
    ER_IDLE, ER_PRE, ER_ERS, ER_TOUT
  } er_t;

  localparam logic [1:0] ARR_NONE  = 2'd0;
  localparam logic [1:0] ARR_PROG0 = 2'd1;
  localparam logic [1:0] ARR_ERASE = 2'd2;

  localparam logic [7:0] D_UNLK1 = 8'hAA;
  localparam logic [7:0] D_UNLK2 = 8'h55;
  localparam logic [7:0] D_SETUP = 8'h80;
  localparam logic [7:0] D_CONF  = 8'h10;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_RST   = 8'hF0;

  localparam logic [15:0] MFR_CODE = 16'h00C2;
  localparam logic [15:0] DEV_CODE = 16'h22FE;
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  output logic              start_erase,
  output logic              id_mode
);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(12'h2AA);

  seq_t seq_q, seq_n;
  logic id_q, id_n;
  logic accept;
  logic at_first, at_second;

  assign accept    = wr_en && !busy;
  assign at_first  = (addr == A_FIRST);
  assign at_second = (addr == A_SECOND);

  always_comb begin
    seq_n       = seq_q;
    id_n        = id_q;
    start_erase = 1'b0;
    if (accept) begin
      seq_n = SQ_IDLE;
      if (cmd == D_RST) begin
        id_n = 1'b0;
      end else begin
        case (seq_q)
          SQ_IDLE:  if (cmd == D_UNLK1 && at_first)  seq_n = SQ_U1;
          SQ_U1:    if (cmd == D_UNLK2 && at_second) seq_n = SQ_U2;
          SQ_U2: begin
            if (at_first && cmd == D_SETUP) seq_n = SQ_SETUP;
            else if (at_first && cmd == D_IDENT) id_n = 1'b1;
          end
          SQ_SETUP: if (cmd == D_UNLK1 && at_first)  seq_n = SQ_SU1;
          SQ_SU1:   if (cmd == D_UNLK2 && at_second) seq_n = SQ_SU2;
          SQ_SU2: begin
            if (cmd == D_CONF && at_first) begin
              start_erase = 1'b1;
              id_n        = 1'b0;
            end
          end
          default:  seq_n = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      id_q  <= 1'b0;
    end else begin
      seq_q <= seq_n;
      id_q  <= id_n;
    end
  end

  assign id_mode = id_q;

  // R3: an erase begins from a clean decoder with ID mode dropped
  p_clean_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (seq_q == SQ_IDLE && !id_q));

  // R6: the decoder does not move while the erase engine is busy
  p_frozen_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(seq_q) && $stable(id_q));
endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import flash_cmd_pkg::*;
#(
  parameter int PRE_CYC  = 64,
  parameter int ERS_CYC  = 256,
  parameter int TOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_hit,
  output logic       busy,
  output logic       tog,
  output logic       tout,
  output logic [1:0] arr_cmd
);
  localparam int PH_MAX = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int EL_W   = $clog2(TOUT_CYC + 1);
  localparam logic [PH_W-1:0] PRE_LAST = PH_W'(PRE_CYC - 1);
  localparam logic [PH_W-1:0] ERS_LAST = PH_W'(ERS_CYC - 1);
  localparam logic [EL_W-1:0] EL_LAST  = EL_W'(TOUT_CYC - 1);

  er_t             st_q;
  logic [PH_W-1:0] ph_q;
  logic [EL_W-1:0] el_q;
  logic            tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ER_IDLE;
      ph_q  <= '0;
      el_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      if (st_q != ER_IDLE && rd_hit) tog_q <= ~tog_q;
      case (st_q)
        ER_IDLE: begin
          if (start) begin
            st_q  <= ER_PRE;
            ph_q  <= '0;
            el_q  <= '0;
            tog_q <= 1'b0;
          end
        end
        ER_PRE, ER_ERS: begin
          el_q <= el_q + 1'b1;
          if (st_q == ER_ERS && ph_q == ERS_LAST) begin
            st_q <= ER_IDLE;
          end else if (el_q == EL_LAST) begin
            st_q <= ER_TOUT;
          end else if (st_q == ER_PRE && ph_q == PRE_LAST) begin
            st_q <= ER_ERS;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= ER_TOUT;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ER_PRE:  arr_cmd = ARR_PROG0;
      ER_ERS:  arr_cmd = ARR_ERASE;
      default: arr_cmd = ARR_NONE;
    endcase
  end

  assign busy = (st_q != ER_IDLE);
  assign tog  = tog_q;
  assign tout = (st_q == ER_TOUT);

  // R3: a decoded confirm starts the engine on the next edge
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R5: erase phase never falls back to preprogram
  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cmd == ARR_ERASE) |=> (arr_cmd != ARR_PROG0));

  // R9: a timeout holds busy and the flag until reset
  p_tout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tout |=> (tout && busy));
endmodule

// File: rtl/read_mux.sv
module read_mux
  import flash_cmd_pkg::*;
(
  input  logic        busy,
  input  logic        tog,
  input  logic        tout,
  input  logic        id_mode,
  input  logic        a6,
  input  logic        a1,
  input  logic        a0,
  input  logic [15:0] arr_rdata,
  output logic [15:0] rdata
);
  logic [15:0] status_w;
  logic [15:0] id_w;

  assign status_w = {8'h00, 1'b0, tog, tout, 5'b00000};

  always_comb begin
    if (!a6 && !a1) id_w = a0 ? DEV_CODE : MFR_CODE;
    else            id_w = 16'h0000;
  end

  always_comb begin
    if (busy)         rdata = status_w;
    else if (id_mode) rdata = id_w;
    else              rdata = arr_rdata;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PRE_CYC  = 64,
  parameter int ERS_CYC  = 256,
  parameter int TOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       arr_rdata,
  output logic [15:0]       rdata,
  output logic              busy,
  output logic [1:0]        arr_cmd
);
  logic wr_en, rd_hit, start_erase, id_mode, tog, tout;

  assign wr_en  = ce && we;
  assign rd_hit = ce && re;

  cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .addr(addr),
    .cmd(wdata[7:0]), .start_erase(start_erase), .id_mode(id_mode)
  );

  erase_engine #(.PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC), .TOUT_CYC(TOUT_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_erase), .rd_hit(rd_hit),
    .busy(busy), .tog(tog), .tout(tout), .arr_cmd(arr_cmd)
  );

  read_mux u_mux (
    .busy(busy), .tog(tog), .tout(tout), .id_mode(id_mode),
    .a6(addr[6]), .a1(addr[1]), .a0(addr[0]),
    .arr_rdata(arr_rdata), .rdata(rdata)
  );

  // R7: status word while busy carries polarity 0 and no stray bits
  p_q7_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rdata[7] == 1'b0 && rdata[15:8] == 8'h00 && rdata[4:0] == 5'b0));

  // R8: consecutive busy reads see bit 6 invert
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_hit) |=> (!busy || rdata[6] != $past(rdata[6])));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int AW = 12;
  localparam int PRE_M = 8, ERS_M = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_m, rdata_t, arr_m, arr_t;
  logic busy_m, busy_t;
  logic [1:0] cmd_m, cmd_t;
  logic [1:0] mst_m, mst_t;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mst_m <= 2'd0; mst_t <= 2'd0; end
    else begin
      if (cmd_m == 2'd1) mst_m <= 2'd1; else if (cmd_m == 2'd2) mst_m <= 2'd2;
      if (cmd_t == 2'd1) mst_t <= 2'd1; else if (cmd_t == 2'd2) mst_t <= 2'd2;
    end
  end
  assign arr_m = (mst_m == 2'd0) ? {12'hA50, addr[3:0]} : (mst_m == 2'd1) ? 16'h0000 : 16'hFFFF;
  assign arr_t = (mst_t == 2'd0) ? {12'hA50, addr[3:0]} : (mst_t == 2'd1) ? 16'h0000 : 16'hFFFF;

  flash_cmd_ctrl #(.ADDR_W(AW), .PRE_CYC(PRE_M), .ERS_CYC(ERS_M), .TOUT_CYC(1000)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .arr_rdata(arr_m), .rdata(rdata_m), .busy(busy_m), .arr_cmd(cmd_m));

  flash_cmd_ctrl #(.ADDR_W(AW), .PRE_CYC(4), .ERS_CYC(20), .TOUT_CYC(10)) i_flash_cmd_ctrl_to (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .arr_rdata(arr_t), .rdata(rdata_t), .busy(busy_t), .arr_cmd(cmd_t));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); ce = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); ce = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] dm, output logic [15:0] dt);
    @(negedge clk); ce = 1'b1; re = 1'b1; addr = a;
    #1; dm = rdata_m; dt = rdata_t;
    @(negedge clk); ce = 1'b0; re = 1'b0;
  endtask

  task automatic erase_seq();
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h80);
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h10);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_m; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] m, t;
    do_reset();
    chk(busy_m == 1'b0, "R1 busy", {15'b0, busy_m}, 16'h0);
    chk(cmd_m == 2'd0, "R1 arr_cmd", {14'b0, cmd_m}, 16'h0);
    rd(12'h003, m, t);
    chk(m == 16'hA503, "R1 array read", m, 16'hA503);
  endtask

  task automatic t_id();
    logic [15:0] m, t;
    do_reset();
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h90);
    rd(12'h000, m, t); chk(m == 16'h00C2, "R2 mfr code", m, 16'h00C2);
    rd(12'h001, m, t); chk(m == 16'h22FE, "R2 dev code", m, 16'h22FE);
    rd(12'h041, m, t); chk(m == 16'h0000, "R2 A6 set", m, 16'h0000);
    rd(12'h002, m, t); chk(m == 16'h0000, "R2 A1 set", m, 16'h0000);
    wr(12'h000, 16'hF0);
    rd(12'h001, m, t); chk(m == 16'hA501, "R2 exit to array", m, 16'hA501);
  endtask

  task automatic t_mismatch();
    logic [15:0] m, t;
    do_reset();
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h80);
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h33); wr(12'h555, 16'h10);
    @(negedge clk);
    chk(busy_m == 1'b0, "R4 broken erase seq", {15'b0, busy_m}, 16'h0);
    wr(12'h555, 16'hAA); wr(12'h123, 16'h55); wr(12'h555, 16'h90);
    rd(12'h000, m, t); chk(m == 16'hA500, "R4 broken id seq", m, 16'hA500);
  endtask

  task automatic t_status();
    logic [15:0] m0, m1, m2, t;
    do_reset();
    erase_seq();
    chk(busy_m == 1'b1, "R3 busy after confirm", {15'b0, busy_m}, 16'h1);
    rd(12'h000, m0, t); rd(12'h555, m1, t); rd(12'h3C7, m2, t);
    chk(m0 == 16'h0000, "R8 first status read", m0, 16'h0000);
    chk(m1 == 16'h0040, "R8 second read toggled", m1, 16'h0040);
    chk(m2 == 16'h0000, "R8 third read toggled back", m2, 16'h0000);
    chk(m1[7] == 1'b0 && m1[5] == 1'b0, "R7 polarity and R9 no timeout", m1, 16'h0040);
    // R6: commands during erase are ignored
    wr(12'h000, 16'hF0);
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h90);
    wait_idle();
    chk(busy_m == 1'b0, "R5 erase ends", {15'b0, busy_m}, 16'h0);
    rd(12'h000, m0, t);
    chk(m0 == 16'hFFFF, "R6 no ID after busy writes / R7 true data", m0, 16'hFFFF);
  endtask

  task automatic t_duration();
    int n1, n2, nb;
    bit back;
    do_reset();
    erase_seq();
    n1 = 0; n2 = 0; nb = 0; back = 1'b0;
    for (int i = 0; i < 200 && busy_m; i++) begin
      nb++;
      if (cmd_m == 2'd1) begin n1++; if (n2 != 0) back = 1'b1; end
      if (cmd_m == 2'd2) n2++;
      @(negedge clk);
    end
    chk(nb == PRE_M + ERS_M, "R5 busy length", 16'(nb), 16'(PRE_M + ERS_M));
    chk(n1 == PRE_M, "R5 preprogram cycles", 16'(n1), 16'(PRE_M));
    chk(n2 == ERS_M, "R5 erase cycles", 16'(n2), 16'(ERS_M));
    chk(!back, "R5 order", {15'b0, back}, 16'h0);
    chk(cmd_m == 2'd0, "R5 arr_cmd idle after", {14'b0, cmd_m}, 16'h0);
  endtask

  task automatic t_timeout();
    logic [15:0] m, t0, t1, t2;
    do_reset();
    erase_seq();
    @(negedge clk);
    rd(12'h000, m, t0);
    chk(t0[5] == 1'b0, "R9 no timeout early", t0, 16'h0000);
    repeat (20) @(negedge clk);
    rd(12'h000, m, t1);
    chk(t1[5] == 1'b1, "R9 timeout flag", t1, {t1[15:6], 1'b1, t1[4:0]});
    rd(12'h010, m, t2);
    chk(t2[6] != t1[6], "R9 toggle continues", t2, {t2[15:7], ~t1[6], t2[5:0]});
    repeat (40) @(negedge clk);
    chk(busy_t == 1'b1, "R9 busy held", {15'b0, busy_t}, 16'h1);
  endtask

  task automatic t_abort();
    logic [15:0] m, t;
    do_reset();
    erase_seq();
    repeat (5) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(busy_m == 1'b0, "R10 busy drops in reset", {15'b0, busy_m}, 16'h0);
    chk(cmd_m == 2'd0, "R10 arr_cmd drops", {14'b0, cmd_m}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy_m == 1'b0, "R10 stays idle", {15'b0, busy_m}, 16'h0);
    rd(12'h002, m, t);
    chk(m == 16'hA502, "R10 array read after abort", m, 16'hA502);
    erase_seq();
    chk(busy_m == 1'b1, "R10 restart accepted", {15'b0, busy_m}, 16'h1);
    wait_idle();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_id();
    t_mismatch();
    t_status();
    t_duration();
    t_timeout();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule